// File: doc/BRIEF.md
# Protection Command Window with Program-Bank Override

This block sits in the low CPU address space of a cartridge bank-switching controller and models a small copy-protection window. It watches CPU writes to three fixed addresses. One address holds a command byte. Two magic values written there, and a write to a neighbouring address while the command byte is zero, ask the main bank logic to switch the whole 32 KB program window to a fixed bank. The request is a bank number and a one-clock load strobe.

A third address picks one of three canned reply bytes. A CPU read of the command address then returns the chosen reply, flagged valid one clock after the read strobe. Reads anywhere else in the window leave the valid flag low, so that the memory behind the window can drive the bus. The command byte is exported so that neighbouring bank logic can qualify its own decodes on it.

Top module: `prot_window`

## Requirements
- R1: Synchronous reset (rst high at a rising clock edge) sets the command byte to 0x01, the reply byte to 0x00, bank_sel to 0, and both bank_load and rd_valid to 0.
- R2: A write to 0x5000 stores the write data as the command byte, which is visible on cmd_byte in the cycle after the write.
- R3: A write of 0xE0 to 0x5000 raises bank_load in the next cycle, with bank_sel = 0.
- R4: A write of 0xEE to 0x5000 raises bank_load in the next cycle, with bank_sel = 3.
- R5: A write to 0x5001 while the command byte (before the write) is 0x00 raises bank_load in the next cycle, with bank_sel = 7. If the command byte is non-zero, the write has no effect on bank_load or bank_sel.
- R6: A write to 0x5080 sets the reply byte: data 0x01 gives 0x83, 0x02 gives 0x42, and 0x03 gives 0x00. Any other data leaves the reply byte unchanged.
- R7: A read of 0x5000 gives rd_valid = 1 and rd_data = the reply byte in the following cycle.
- R8: A read of any other address gives rd_valid = 0 and rd_data = 0x00 in the following cycle.
- R9: bank_load is high for exactly one cycle per qualifying write. Writes of other values to 0x5000 do not pulse it, and bank_sel holds the last requested bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Reply byte, registered |
| rd_valid | output | 1 | rd_data is driven by this block |
| cmd_byte | output | 8 | Current command byte |
| bank_sel | output | 3 | Requested 32 KB program bank |
| bank_load | output | 1 | One-cycle strobe that applies bank_sel |

## Verification
The hardest state to reach is the armed condition for the 0x5001 write. Reset leaves the command byte at 0x01, so that write has no effect until the CPU has first stored zero at 0x5000. The stimulus first writes 0x5001 with a non-zero command byte and confirms there is no strobe. It then clears the command byte and writes 0x5001 twice back to back, which proves that the strobe repeats on every qualifying write. Reply selection is checked by reading back after each selector write, including a selector value outside the three known codes.

// File: rtl/prot_window.sv
module prot_window #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 3,
  parameter logic [AW-1:0] CMD_ADDR  = 16'h5000,
  parameter logic [AW-1:0] ARM_ADDR  = 16'h5001,
  parameter logic [AW-1:0] SEL_ADDR  = 16'h5080,
  parameter logic [DW-1:0] CMD_RESET = 8'h01,
  parameter logic [DW-1:0] LOW_KEY   = 8'hE0,
  parameter logic [DW-1:0] HIGH_KEY  = 8'hEE,
  parameter logic [BW-1:0] LOW_BANK  = 3'd0,
  parameter logic [BW-1:0] HIGH_BANK = 3'd3,
  parameter logic [BW-1:0] ARM_BANK  = 3'd7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [DW-1:0] cmd_byte,
  output logic [BW-1:0] bank_sel,
  output logic          bank_load
);

  logic [DW-1:0] cmd_q, resp_q, resp_nx;
  logic [BW-1:0] sel_q, sel_nx;
  logic          load_q, rv_q;
  logic [DW-1:0] rd_q;

  wire wr_cmd = cpu_wr && (cpu_addr == CMD_ADDR);
  wire wr_arm = cpu_wr && (cpu_addr == ARM_ADDR);
  wire wr_sel = cpu_wr && (cpu_addr == SEL_ADDR);
  wire rd_hit = cpu_rd && (cpu_addr == CMD_ADDR);

  wire key_lo = wr_cmd && (cpu_wdata == LOW_KEY);
  wire key_hi = wr_cmd && (cpu_wdata == HIGH_KEY);
  wire armed  = wr_arm && (cmd_q == '0);
  wire load_req = key_lo || key_hi || armed;

  always_comb begin
    sel_nx = sel_q;
    if (armed)       sel_nx = ARM_BANK;
    else if (key_hi) sel_nx = HIGH_BANK;
    else if (key_lo) sel_nx = LOW_BANK;
  end

  always_comb begin
    resp_nx = resp_q;
    if (wr_sel) begin
      case (cpu_wdata)
        8'h01:   resp_nx = 8'h83;
        8'h02:   resp_nx = 8'h42;
        8'h03:   resp_nx = 8'h00;
        default: resp_nx = resp_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_RESET;
      resp_q <= '0;
      sel_q  <= '0;
      load_q <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_cmd) cmd_q <= cpu_wdata;
      resp_q <= resp_nx;
      sel_q  <= sel_nx;
      load_q <= load_req;
      rv_q   <= rd_hit;
      rd_q   <= rd_hit ? resp_q : '0;
    end
  end

  assign cmd_byte  = cmd_q;
  assign bank_sel  = sel_q;
  assign bank_load = load_q;
  assign rd_valid  = rv_q;
  assign rd_data   = rd_q;

endmodule

module prot_window_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic [7:0]  cmd_byte,
  input logic [2:0]  bank_sel,
  input logic        bank_load,
  input logic [7:0]  resp
);

  assert_cmd_store_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h5000) |=> cmd_byte == $past(cpu_wdata));

  assert_low_key_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h5000 && cpu_wdata == 8'hE0) |=> (bank_load && bank_sel == 3'd0));

  assert_high_key_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h5000 && cpu_wdata == 8'hEE) |=> (bank_load && bank_sel == 3'd3));

  assert_armed_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h5001 && cmd_byte == 8'h00) |=> (bank_load && bank_sel == 3'd7));

  assert_reply_one_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h5080 && cpu_wdata == 8'h01) |=> resp == 8'h83);

  assert_reply_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (!(cpu_wr && cpu_addr == 16'h5080)) |=> $stable(resp));

  assert_read_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 16'h5000) |=> (rd_valid && rd_data == $past(resp)));

  assert_read_miss_R8: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_addr == 16'h5000) |=> (!rd_valid && rd_data == 8'h00));

  assert_load_cause_R9: assert property (@(posedge clk) disable iff (rst)
    bank_load |-> $past(cpu_wr));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bank_load |-> (bank_sel == $past(bank_sel)));

endmodule

bind prot_window prot_window_chk u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_data(rd_data), .rd_valid(rd_valid),
  .cmd_byte(cmd_byte), .bank_sel(bank_sel), .bank_load(bank_load), .resp(resp_q)
);

// File: tb/prot_window_bench.sv
module prot_window_bench;
  logic clk = 0, rst = 1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] rd_data, cmd_byte;
  logic rd_valid, bank_load;
  logic [2:0] bank_sel;

  always #2 clk = ~clk;

  prot_window u_prot_window (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_data(rd_data), .rd_valid(rd_valid),
    .cmd_byte(cmd_byte), .bank_sel(bank_sel), .bank_load(bank_load)
  );

  typedef struct {
    int         due;
    logic       load;
    logic [2:0] sel;
    logic       rv;
    logic [7:0] rd;
    logic [7:0] cmd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_cmd = 8'h01, m_resp = 8'h00;
  logic [2:0] m_sel = 3'd0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (bank_load !== e.load || bank_sel !== e.sel || rd_valid !== e.rv ||
          rd_data !== e.rd || cmd_byte !== e.cmd) begin
        fails++;
        $display("FAIL %s: got load=%0b sel=%0d rv=%0b rd=%02h cmd=%02h exp load=%0b sel=%0d rv=%0b rd=%02h cmd=%02h",
          e.tag, bank_load, bank_sel, rd_valid, rd_data, cmd_byte,
          e.load, e.sel, e.rv, e.rd, e.cmd);
      end
    end
  end

  task automatic op(input logic wr, input logic rd, input logic [15:0] a,
                    input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    e.load = 0; e.rv = 0; e.rd = 8'h00;
    if (wr && a == 16'h5000 && (d == 8'hE0 || d == 8'hEE)) begin
      e.load = 1; m_sel = (d == 8'hEE) ? 3'd3 : 3'd0;
    end
    if (wr && a == 16'h5001 && m_cmd == 8'h00) begin
      e.load = 1; m_sel = 3'd7;
    end
    if (rd && a == 16'h5000) begin
      e.rv = 1; e.rd = m_resp;
    end
    if (wr && a == 16'h5000) m_cmd = d;
    if (wr && a == 16'h5080) begin
      if (d == 8'h01) m_resp = 8'h83;
      else if (d == 8'h02) m_resp = 8'h42;
      else if (d == 8'h03) m_resp = 8'h00;
    end
    e.sel = m_sel; e.cmd = m_cmd; e.tag = tag; e.due = cyc + 1;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cmd_byte !== 8'h01 || bank_sel !== 3'd0 || bank_load !== 0 || rd_valid !== 0 || rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: cmd=%02h sel=%0d load=%0b rv=%0b rd=%02h exp 01 0 0 0 00",
        cmd_byte, bank_sel, bank_load, rd_valid, rd_data);
    end
    rst = 0;
    op(0, 1, 16'h5000, 8'h00, "R1 reply cleared by reset R7");
    op(1, 0, 16'h5001, 8'h55, "R5 not armed after reset");
    op(1, 0, 16'h5000, 8'h12, "R2 store cmd, R9 no pulse");
    op(1, 0, 16'h5001, 8'h00, "R5 not armed cmd=12");
    op(1, 0, 16'h5000, 8'hE0, "R3 low key bank 0");
    op(0, 0, 16'h0000, 8'h00, "R9 pulse one cycle");
    op(1, 0, 16'h5000, 8'hEE, "R4 high key bank 3");
    op(1, 0, 16'h5000, 8'h00, "R9 sel holds, R2 cmd 00");
    op(1, 0, 16'h5001, 8'hAA, "R5 armed bank 7");
    op(1, 0, 16'h5001, 8'h01, "R5 R9 back to back pulse");
    op(0, 0, 16'h0000, 8'h00, "R9 pulse ends");
    op(1, 0, 16'h5080, 8'h01, "R6 select 1");
    op(0, 1, 16'h5000, 8'h00, "R6 R7 reply 83");
    op(1, 0, 16'h5080, 8'h02, "R6 select 2");
    op(0, 1, 16'h5000, 8'h00, "R6 R7 reply 42");
    op(1, 0, 16'h5080, 8'h07, "R6 unknown select");
    op(0, 1, 16'h5000, 8'h00, "R6 reply kept 42");
    op(0, 1, 16'h5001, 8'h00, "R8 read 5001");
    op(0, 1, 16'h6000, 8'h00, "R8 read 6000");
    op(1, 0, 16'h5080, 8'h03, "R6 select 3");
    op(0, 1, 16'h5000, 8'h00, "R6 R7 reply 00");
    op(0, 0, 16'h0000, 8'h00, "idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule